// File: doc/BRIEF.md
# Timed-Unlock Nonvolatile Byte Store Controller

This block sits on a CPU's byte-wide I/O bus and gives software read and write access to a 2048-byte nonvolatile data store. The store is modelled here as an internal byte array. Software sees four byte registers: a low and a high address byte, a data byte and a control byte. A read is requested by setting a read-request bit. The addressed byte then lands in the data register one cycle later.

A write is guarded by a two-step sequence. Software first sets an unlock bit, which opens a window that closes by itself after four cycles. A program-request bit set inside that window starts the write. The program-request bit then stays high for a fixed busy period, and the array is updated at the end of it. While busy, the address and data registers are frozen and read requests are dropped. A ready interrupt is a level. It is held whenever the controller is not programming, its local enable is set and the CPU's global interrupt enable is set.

The controller is a three-state machine. `ST_IDLE` accepts register writes and requests. The transition *idle→read* happens on a read request, and `ST_READ` lasts one cycle and returns through *read→idle* after loading the data register. The transition *idle→program* happens on an unlocked program request. `ST_PROG` lasts for the busy period and leaves through *program→idle* on the cycle that commits the byte. A program request wins over a read request written in the same control write.

Top module: `nvm_ctrl`

## Requirements
- R1: The address is 11 bits. The low byte at offset 0x1E holds bits 7:0. The high byte at offset 0x1F holds bits 10:8 in its bits 2:0, its bits 7:3 read as zero, and writes to those bits are dropped. The address has no reset value.
- R2: The data register at offset 0x1D resets to 0x00 and reads back what was written to it.
- R3: The control register sits at offset 0x1C: bit 0 is read-request, bit 1 is program-request (busy), bit 2 is unlock and bit 3 is ready-interrupt enable. Bits 7:4 read zero, and the register reads 0x00 after reset.
- R4: Writing 1 to the unlock bit makes it read 1 for exactly four cycles, after which hardware clears it. A program request written on any of the four edges that follow the unlocking write starts a write.
- R5: A program request written while the unlock bit reads 0 (never set, or already expired) does nothing: the busy bit stays 0 and the array keeps its old byte.
- R6: After an accepted program request, the busy bit reads 1 for exactly BUSY_CYCLES (64) cycles. The byte is stored at the end of that period and the busy bit then reads 0.
- R7: A read request written while idle sets the read-request bit for one cycle, loads the addressed byte into the data register on the next edge, and clears itself. A read request written while busy is dropped, and the data register stays unchanged.
- R8: While busy, writes to the address bytes and the data register are dropped.
- R9: `ready_irq` is 1 exactly when the interrupt enable bit is 1, `irq_global_en` is 1 and the busy bit is 0. It is a level, not a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 6 | Register offset on the I/O bus |
| io_wr | input | 1 | Register write strobe, one cycle per write |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data of the register at `io_addr` (combinational) |
| irq_global_en | input | 1 | Global interrupt enable from the CPU |
| ready_irq | output | 1 | Ready interrupt level |

## Verification
A state machine stuck in or falling out of `ST_PROG` shows at once in the busy bit of the control register and in `ready_irq`. The bench checks both on the exact cycles where the busy period should begin and end. A miscounted unlock timer shows as the unlock bit reading 1 one cycle too few or too many times, or as a program request on the fourth edge being refused or one on the fifth being accepted. A wrong commit address or a late read load only shows after a later read request, one cycle after it, so each write is followed by a read of the same location and of a location that must not have changed.

// File: rtl/nvm_pkg.sv
`timescale 1ns/10ps
package nvm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_PROG = 2'd2
    } nvm_state_e;

    localparam logic [5:0] OFF_CTRL    = 6'h1C;
    localparam logic [5:0] OFF_DATA    = 6'h1D;
    localparam logic [5:0] OFF_ADDR_LO = 6'h1E;
    localparam logic [5:0] OFF_ADDR_HI = 6'h1F;

    localparam int BIT_RDREQ  = 0;
    localparam int BIT_PGREQ  = 1;
    localparam int BIT_UNLOCK = 2;
    localparam int BIT_IRQEN  = 3;
endpackage

// File: rtl/nvm_unlock_win.sv
`timescale 1ns/10ps
module nvm_unlock_win #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic open_o
);
    localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o <= 1'b0;
            left_q <= '0;
        end else if (arm) begin
            open_o <= 1'b1;
            left_q <= CW'(WINDOW - 1);
        end else if (open_o) begin
            if (left_q == '0) open_o <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end
    end
endmodule

// File: rtl/nvm_busy_timer.sv
`timescale 1ns/10ps
module nvm_busy_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= CW'(CYCLES - 1);
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign done = run && (cnt_q == '0);
endmodule

// File: rtl/nvm_cells.sv
`timescale 1ns/10ps
module nvm_cells #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/nvm_ctrl.sv
`timescale 1ns/10ps
module nvm_ctrl
    import nvm_pkg::*;
#(
    parameter int DEPTH         = 2048,
    parameter int BUSY_CYCLES   = 64,
    parameter int UNLOCK_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] io_addr,
    input  logic       io_wr,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    input  logic       irq_global_en,
    output logic       ready_irq
);
    localparam int AW = $clog2(DEPTH);
    localparam int HW = AW - 8;

    nvm_state_e state_q, state_d;

    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          irqen_q;
    logic          mwe_open;
    logic          prog_done;
    logic [7:0]    cell_rdata;

    logic wr_ctrl, wr_data, wr_lo, wr_hi;
    logic start_prog, start_read;
    logic busy, re_bit, load_data, cell_we;

    assign wr_ctrl = io_wr && (io_addr == OFF_CTRL);
    assign wr_data = io_wr && (io_addr == OFF_DATA);
    assign wr_lo   = io_wr && (io_addr == OFF_ADDR_LO);
    assign wr_hi   = io_wr && (io_addr == OFF_ADDR_HI);

    assign start_prog = wr_ctrl && io_wdata[BIT_PGREQ] && mwe_open && (state_q == ST_IDLE);
    assign start_read = wr_ctrl && io_wdata[BIT_RDREQ] && (state_q == ST_IDLE) && !start_prog;

    nvm_unlock_win #(.WINDOW(UNLOCK_CYCLES)) u_unlock (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (wr_ctrl && io_wdata[BIT_UNLOCK]),
        .open_o (mwe_open)
    );

    nvm_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start_prog),
        .run   (busy),
        .done  (prog_done)
    );

    nvm_cells #(.DEPTH(DEPTH)) u_cells (
        .clk   (clk),
        .we    (cell_we),
        .addr  (addr_q),
        .wdata (data_q),
        .rdata (cell_rdata)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: idle->read, idle->program, read->idle, program->idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_prog)      state_d = ST_PROG;
                else if (start_read) state_d = ST_READ;
            end
            ST_READ: state_d = ST_IDLE;
            ST_PROG: if (prog_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        busy      = 1'b0;
        re_bit    = 1'b0;
        load_data = 1'b0;
        cell_we   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin
                re_bit    = 1'b1;
                load_data = 1'b1;
            end
            ST_PROG: begin
                busy    = 1'b1;
                cell_we = prog_done;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                data_q <= 8'h00;
        else if (load_data)        data_q <= cell_rdata;
        else if (wr_data && !busy) data_q <= io_wdata;
    end

    // Address has no reset value; software loads it before use
    always_ff @(posedge clk) begin
        if (!busy) begin
            if (wr_lo) addr_q[7:0]    <= io_wdata;
            if (wr_hi) addr_q[AW-1:8] <= io_wdata[HW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       irqen_q <= 1'b0;
        else if (wr_ctrl) irqen_q <= io_wdata[BIT_IRQEN];
    end

    always_comb begin
        case (io_addr)
            OFF_CTRL:    io_rdata = {4'b0000, irqen_q, mwe_open, busy, re_bit};
            OFF_DATA:    io_rdata = data_q;
            OFF_ADDR_LO: io_rdata = addr_q[7:0];
            OFF_ADDR_HI: io_rdata = {{(16 - AW){1'b0}}, addr_q[AW-1:8]};
            default:     io_rdata = 8'h00;
        endcase
    end

    assign ready_irq = irqen_q && irq_global_en && !busy;
endmodule

// File: rtl/nvm_ctrl_chk.sv
`timescale 1ns/10ps
module nvm_ctrl_chk
    import nvm_pkg::*;
#(
    parameter int UNLOCK_CYCLES = 4,
    parameter int AW            = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          io_wr,
    input logic [5:0]    io_addr,
    input logic [7:0]    io_wdata,
    input logic          irq_global_en,
    input logic          ready_irq,
    input logic          mwe_open,
    input logic          busy,
    input logic          re_bit,
    input logic [AW-1:0] addr_q,
    input logic [7:0]    data_q
);
    logic        arm_seen;
    logic [15:0] age_q;

    assign arm_seen = io_wr && (io_addr == OFF_CTRL) && io_wdata[BIT_UNLOCK];

    always_ff @(posedge clk) begin
        if (!rst_n)                             age_q <= '0;
        else if (arm_seen)                      age_q <= 16'd1;
        else if (mwe_open && age_q != 16'hFFFF) age_q <= age_q + 16'd1;
        else if (!mwe_open)                     age_q <= '0;
    end

    a_r4_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        mwe_open |-> (age_q <= 16'(UNLOCK_CYCLES)));

    a_r4_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
        arm_seen |=> mwe_open);

    a_r5_locked_request: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == OFF_CTRL && io_wdata[BIT_PGREQ] && !mwe_open && !busy) |=> !busy);

    a_r7_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        re_bit |=> !re_bit);

    a_r7_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !re_bit);

    a_r8_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && io_wr && (io_addr == OFF_ADDR_LO || io_addr == OFF_ADDR_HI)) |=> $stable(addr_q));

    a_r8_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && io_wr && io_addr == OFF_DATA) |=> $stable(data_q));

    a_r9_irq_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready_irq);

    a_r9_irq_needs_global: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_global_en |-> !ready_irq);
endmodule

bind nvm_ctrl nvm_ctrl_chk #(.UNLOCK_CYCLES(UNLOCK_CYCLES), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_wr         (io_wr),
    .io_addr       (io_addr),
    .io_wdata      (io_wdata),
    .irq_global_en (irq_global_en),
    .ready_irq     (ready_irq),
    .mwe_open      (mwe_open),
    .busy          (busy),
    .re_bit        (re_bit),
    .addr_q        (addr_q),
    .data_q        (data_q)
);

// File: tb/nvm_ctrl_test.sv
`timescale 1ns/10ps
module nvm_ctrl_test;
    localparam logic [5:0] A_CTRL = 6'h1C;
    localparam logic [5:0] A_DATA = 6'h1D;
    localparam logic [5:0] A_LO   = 6'h1E;
    localparam logic [5:0] A_HI   = 6'h1F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] io_addr = 6'h00;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       irq_global_en = 1'b0;
    logic       ready_irq;

    int tests = 0;
    int fails = 0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } item_t;

    item_t exp_q[$];
    event  mon_evt;

    always #2.5 clk = ~clk;

    nvm_ctrl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .io_addr       (io_addr),
        .io_wr         (io_wr),
        .io_wdata      (io_wdata),
        .io_rdata      (io_rdata),
        .irq_global_en (irq_global_en),
        .ready_irq     (ready_irq)
    );

    // Monitor: pops the expected item and compares the observed register value
    always begin
        @(mon_evt);
        while (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            tests++;
            if ((io_rdata & it.mask) !== (it.exp & it.mask)) begin
                fails++;
                $display("FAIL %s: got %02h expected %02h (mask %02h)",
                         it.tag, io_rdata & it.mask, it.exp & it.mask, it.mask);
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: pushes the expected value and hands it to the monitor
    task automatic expect_reg(input logic [5:0] a, input logic [7:0] e,
                              input logic [7:0] m, input string tag);
        io_addr = a;
        #0.1;
        exp_q.push_back('{exp: e, mask: m, tag: tag});
        -> mon_evt;
        #0.1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        #0.1;
        tests++;
        if (ready_irq !== e) begin
            fails++;
            $display("FAIL %s: ready_irq got %0b expected %0b", tag, ready_irq, e);
        end
    endtask

    task automatic wait_not_busy();
        for (int i = 0; i < 200; i++) begin
            io_addr = A_CTRL;
            #0.1;
            if (io_rdata[1] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic set_addr(input logic [10:0] a);
        wr(A_HI, {5'b0, a[10:8]});
        wr(A_LO, a[7:0]);
    endtask

    task automatic do_read(input logic [7:0] ctrl_irq);
        wr(A_DATA, 8'h00);
        wr(A_CTRL, ctrl_irq | 8'h01);
        idle(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);

        // Reset state
        expect_reg(A_DATA, 8'h00, 8'hFF, "R2 data reset value");
        expect_reg(A_CTRL, 8'h00, 8'hFF, "R3 control reset value");
        irq_global_en = 1'b1;
        expect_irq(1'b0, "R9 irq off while enable bit clear");

        // Address register width and reserved bits
        wr(A_HI, 8'hFF);
        expect_reg(A_HI, 8'h07, 8'hFF, "R1 high byte reserved bits read zero");
        wr(A_LO, 8'h5A);
        expect_reg(A_LO, 8'h5A, 8'hFF, "R1 low byte readback");
        wr(A_DATA, 8'hC3);
        expect_reg(A_DATA, 8'hC3, 8'hFF, "R2 data readback");
        wr(A_CTRL, 8'hF0);
        expect_reg(A_CTRL, 8'h00, 8'hF0, "R3 control bits 7:4 read zero");

        // Unlocked write to 0x75A, busy window length
        wr(A_CTRL, 8'h04);
        wr(A_CTRL, 8'h02);
        expect_reg(A_CTRL, 8'h02, 8'h02, "R6 busy set after unlocked request");
        idle(63);
        expect_reg(A_CTRL, 8'h02, 8'h02, "R6 busy still set in last busy cycle");
        idle(1);
        expect_reg(A_CTRL, 8'h00, 8'h02, "R6 busy clear after busy period");

        // Read back 0x75A
        wr(A_DATA, 8'h00);
        wr(A_CTRL, 8'h01);
        expect_reg(A_CTRL, 8'h01, 8'h01, "R7 read request visible for one cycle");
        idle(1);
        expect_reg(A_CTRL, 8'h00, 8'h01, "R7 read request clears itself");
        expect_reg(A_DATA, 8'hC3, 8'hFF, "R7 read loads stored byte");

        // Window: request on the fourth edge after unlocking
        set_addr(11'h123);
        wr(A_DATA, 8'h3C);
        wr(A_CTRL, 8'h04);
        idle(3);
        expect_reg(A_CTRL, 8'h04, 8'h04, "R4 unlock bit still set after three cycles");
        wr(A_CTRL, 8'h02);
        expect_reg(A_CTRL, 8'h02, 8'h06, "R4 request on fourth edge accepted, unlock expired");

        // Frozen registers and dropped read while busy
        wr(A_LO, 8'h77);
        wr(A_HI, 8'h05);
        wr(A_DATA, 8'h99);
        expect_reg(A_LO, 8'h23, 8'hFF, "R8 address low frozen while busy");
        expect_reg(A_HI, 8'h01, 8'hFF, "R8 address high frozen while busy");
        expect_reg(A_DATA, 8'h3C, 8'hFF, "R8 data frozen while busy");
        wr(A_CTRL, 8'h09);
        expect_reg(A_CTRL, 8'h00, 8'h01, "R7 read request dropped while busy");
        idle(1);
        expect_reg(A_DATA, 8'h3C, 8'hFF, "R7 data unchanged after dropped read");
        expect_irq(1'b0, "R9 irq held low while busy");

        wait_not_busy();
        expect_irq(1'b1, "R9 irq high when idle and enabled");
        irq_global_en = 1'b0;
        expect_irq(1'b0, "R9 irq low with global enable clear");
        irq_global_en = 1'b1;
        expect_irq(1'b1, "R9 irq level stays while idle");
        idle(5);
        expect_irq(1'b1, "R9 irq level still held later");

        do_read(8'h08);
        expect_reg(A_DATA, 8'h3C, 8'hFF, "R4 byte written via fourth-edge request");
        set_addr(11'h75A);
        do_read(8'h08);
        expect_reg(A_DATA, 8'hC3, 8'hFF, "R8 earlier location unaffected by dropped writes");

        // Known byte at 0x7FF, then an expired-window attempt
        set_addr(11'h7FF);
        wr(A_DATA, 8'h11);
        wr(A_CTRL, 8'h0C);
        wr(A_CTRL, 8'h0A);
        wait_not_busy();
        wr(A_DATA, 8'hEE);
        wr(A_CTRL, 8'h0C);
        idle(3);
        expect_reg(A_CTRL, 8'h04, 8'h04, "R4 unlock set in fourth cycle");
        idle(1);
        expect_reg(A_CTRL, 8'h00, 8'h04, "R4 unlock cleared after four cycles");
        wr(A_CTRL, 8'h0A);
        expect_reg(A_CTRL, 8'h00, 8'h02, "R5 request after expiry ignored");
        expect_irq(1'b1, "R5 irq stays high, no busy started");
        wr(A_CTRL, 8'h0A);
        expect_reg(A_CTRL, 8'h00, 8'h02, "R5 request without unlock ignored");
        do_read(8'h08);
        expect_reg(A_DATA, 8'h11, 8'hFF, "R5 array keeps old byte");

        // Same-write priority: unlocked request with read bit set
        wr(A_DATA, 8'h5E);
        wr(A_CTRL, 8'h04);
        wr(A_CTRL, 8'h03);
        expect_reg(A_CTRL, 8'h02, 8'h03, "R6 program wins over read in same write");
        wait_not_busy();
        do_read(8'h00);
        expect_reg(A_DATA, 8'h5E, 8'hFF, "R6 byte stored at end of busy period");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule